// File: doc/BRIEF.md
# Partial Word Store Byte-Lane Generator

This block turns a partial-word store request into one aligned memory write with per-byte enables. A request carries a register value, a byte address and a mode bit. In the leading-edge mode the store covers the bytes from the addressed byte to the end of the word. In the trailing-edge mode it covers the bytes before the addressed byte. Byte numbering is big-endian, so byte 0 is the most significant lane.

The output address is always word aligned. The write data keeps each register byte on its own lane, and lanes that are not written carry zero. One case writes nothing: trailing-edge mode with an aligned address. For that case the block raises a probe strobe in place of a write strobe, so that the memory side still checks access rights and marks the line dirty. Every three-byte case leaves as a single write. All outputs are registered, and each response appears exactly one cycle after its request.

Top module: `pws_lane_gen`

## Requirements
- R1: While reset is asserted and until the first request, `wr_valid` and `probe_valid` are low, and `wr_be`, `wr_data` and `wr_addr` are zero.
- R2: A request with `req_valid` high at a clock edge produces exactly one strobe at the next edge: either `wr_valid` or `probe_valid`, never both. A cycle with no request produces no strobe at the following edge.
- R3: `wr_addr` equals the request address with its two low bits cleared. The offset is `req_addr[1:0]`.
- R4: Leading-edge mode (`req_mode` = 0) enables bytes offset..3. Enable bit 3 is byte 0 (`wr_data[31:24]`) and bit 0 is byte 3 (`wr_data[7:0]`). Offset 0 gives `wr_be` 4'b1111, offset 1 gives 4'b0111, offset 2 gives 4'b0011 and offset 3 gives 4'b0001.
- R5: In leading-edge mode every enabled lane carries the register byte with the same significance. For example, offset 2 places `req_data[15:0]` on `wr_data[15:0]`.
- R6: Trailing-edge mode (`req_mode` = 1) with offset 1, 2 or 3 enables bytes 0..offset-1, giving 4'b1000, 4'b1100 or 4'b1110. These lanes carry the upper register bytes in place, and byte 3 is never enabled.
- R7: Trailing-edge mode with offset 0 raises `probe_valid` with `wr_valid` low, `wr_be` 4'b0000 and `wr_data` zero.
- R8: Every lane whose enable bit is low carries zero data.
- R9: The three-byte cases (leading-edge offset 1, trailing-edge offset 3) are issued as one `wr_valid` pulse carrying all three enables.
- R10: Requests in consecutive cycles give responses in consecutive cycles, in order, with no request lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_mode | input | 1 | 0 = leading-edge store, 1 = trailing-edge store |
| req_addr | input | ADDR_W | Byte address of the request |
| req_data | input | 32 | Register value to store |
| wr_valid | output | 1 | Write strobe, one cycle after the request |
| probe_valid | output | 1 | Zero-length access strobe for the empty case |
| wr_addr | output | ADDR_W | Word-aligned address |
| wr_data | output | 32 | Lane-placed write data |
| wr_be | output | 4 | Byte enables, bit 3 = byte 0 |

## Verification
The assertions assume that `req_mode`, `req_addr` and `req_data` are stable and known whenever `req_valid` is high. They also assume that reset is released before the first request, because several properties compare an output with the request from the previous cycle. The bench drives every input at the falling edge and never leaves `req_valid` high with an undriven payload. It covers all eight mode and offset pairs, then runs a back-to-back burst and a gapped burst whose addresses and data come from an LFSR.

// File: rtl/pws_pkg.sv
package pws_pkg;

   typedef enum logic {
      PWS_MODE_LEAD  = 1'b0,
      PWS_MODE_TRAIL = 1'b1
   } pws_mode_e;

endpackage

// File: rtl/pws_lane_decode.sv
module pws_lane_decode #(
   parameter int LANES = 4,
   parameter int OFF_W = $clog2(LANES)
) (
   input  logic             mode,
   input  logic [OFF_W-1:0] off,
   output logic [LANES-1:0] be,
   output logic             probe
);
   import pws_pkg::*;

   pws_mode_e mode_e;
   assign mode_e = pws_mode_e'(mode);

   // lane k holds byte number LANES-1-k (big-endian)
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [OFF_W-1:0] BYTE_NUM = OFF_W'(LANES - 1 - k);
      always_comb begin
         if (mode_e == PWS_MODE_TRAIL) be[k] = (BYTE_NUM < off);
         else                          be[k] = (BYTE_NUM >= off);
      end
   end

   assign probe = (mode_e == PWS_MODE_TRAIL) && (off == '0);

endmodule

// File: rtl/pws_data_steer.sv
module pws_data_steer #(
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   parameter int DATA_W = LANES * LANE_W
) (
   input  logic [DATA_W-1:0] din,
   input  logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] dout
);
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign dout[k*LANE_W +: LANE_W] = be[k] ? din[k*LANE_W +: LANE_W] : '0;
   end
endmodule

// File: rtl/pws_out_stage.sv
module pws_out_stage #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LANES      = 4,
   parameter bit CLEAR_IDLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              probe_in,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic [LANES-1:0]  be_in,
   output logic              wr_valid,
   output logic              probe_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [LANES-1:0]  wr_be
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_valid    <= 1'b0;
         probe_valid <= 1'b0;
      end else begin
         wr_valid    <= load && !probe_in;
         probe_valid <= load && probe_in;
      end
   end

   if (CLEAR_IDLE) begin : g_clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
            wr_be   <= '0;
         end else if (load) begin
            wr_addr <= addr_in;
            wr_data <= data_in;
            wr_be   <= be_in;
         end else begin
            wr_addr <= '0;
            wr_data <= '0;
            wr_be   <= '0;
         end
      end
   end else begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
            wr_be   <= '0;
         end else if (load) begin
            wr_addr <= addr_in;
            wr_data <= data_in;
            wr_be   <= be_in;
         end
      end
   end
endmodule

// File: rtl/pws_lane_gen.sv
module pws_lane_gen #(
   parameter int ADDR_W     = 32,
   parameter int LANE_W     = 8,
   parameter int LANES      = 4,
   parameter bit CLEAR_IDLE = 1'b0,
   localparam int DATA_W    = LANE_W * LANES,
   localparam int OFF_W     = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_mode,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              wr_valid,
   output logic              probe_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [LANES-1:0]  wr_be
);
   if (LANES < 2 || (1 << OFF_W) != LANES) begin : g_bad_lanes
      $error("pws_lane_gen: LANES must be a power of two, at least 2");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("pws_lane_gen: ADDR_W must exceed the offset width");
   end
   if (LANE_W < 1) begin : g_bad_lane_w
      $error("pws_lane_gen: LANE_W must be positive");
   end

   logic [OFF_W-1:0]  off;
   logic [ADDR_W-1:0] addr_al;
   logic [LANES-1:0]  be_c;
   logic [DATA_W-1:0] data_c;
   logic              probe_c;

   assign off     = req_addr[OFF_W-1:0];
   assign addr_al = {req_addr[ADDR_W-1:OFF_W], OFF_W'(0)};

   pws_lane_decode #(.LANES(LANES), .OFF_W(OFF_W)) u_decode (
      .mode  (req_mode),
      .off   (off),
      .be    (be_c),
      .probe (probe_c)
   );

   pws_data_steer #(.LANES(LANES), .LANE_W(LANE_W), .DATA_W(DATA_W)) u_steer (
      .din  (req_data),
      .be   (be_c),
      .dout (data_c)
   );

   pws_out_stage #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .CLEAR_IDLE(CLEAR_IDLE)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (req_valid),
      .probe_in    (probe_c),
      .addr_in     (addr_al),
      .data_in     (data_c),
      .be_in       (be_c),
      .wr_valid    (wr_valid),
      .probe_valid (probe_valid),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .wr_be       (wr_be)
   );
endmodule

// File: rtl/pws_lane_gen_chk.sv
module pws_lane_gen_chk #(
   parameter int ADDR_W = 32,
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int DATA_W = LANE_W * LANES,
   localparam int OFF_W  = $clog2(LANES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_mode,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_data,
   input logic              wr_valid,
   input logic              probe_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [LANES-1:0]  wr_be
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((1 << OFF_W) - 1);

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> ($countones({wr_valid, probe_valid}) == 1)); // R2

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!wr_valid && !probe_valid)); // R2

   AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (wr_addr == ($past(req_addr) & ALIGN_MASK))); // R3

   AST_LEAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_mode && req_addr[OFF_W-1:0] == '0)
      |=> (wr_valid && (&wr_be) && wr_data == $past(req_data))); // R4

   AST_LEAD_LAST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_mode) |=> wr_be[0]); // R4

   AST_TRAIL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode) |=> !wr_be[0]); // R6

   AST_TRAIL_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode && req_addr[OFF_W-1:0] == '0)
      |=> (probe_valid && !wr_valid && wr_be == '0)); // R7

   for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
      AST_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_valid || probe_valid) && !wr_be[k]
         |-> (wr_data[k*LANE_W +: LANE_W] == '0)); // R8
   end
endmodule

bind pws_lane_gen pws_lane_gen_chk #(
   .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_mode    (req_mode),
   .req_addr    (req_addr),
   .req_data    (req_data),
   .wr_valid    (wr_valid),
   .probe_valid (probe_valid),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .wr_be       (wr_be)
);

// File: tb/tb_pws_lane_gen.sv
`timescale 1ns/1ps
module tb_pws_lane_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_mode = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_data = '0;
   logic        wr_valid, probe_valid;
   logic [31:0] wr_addr, wr_data;
   logic [3:0]  wr_be;

   pws_lane_gen dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_addr(req_addr), .req_data(req_data), .wr_valid(wr_valid),
      .probe_valid(probe_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_be(wr_be)
   );

   always #4 clk = ~clk;   // 125 MHz

   typedef struct {
      logic        wv;
      logic        pv;
      logic [31:0] addr;
      logic [31:0] data;
      logic [3:0]  be;
      int          due;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   bit   mon_on = 1'b0;
   bit   summary_done = 1'b0;
   logic [31:0] lfsr = 32'hACE1_2468;

   always @(posedge clk) cyc++;

   function automatic logic [3:0] model_be(logic mode, logic [1:0] off);
      case ({mode, off})
         3'b0_00: return 4'b1111;   // R4
         3'b0_01: return 4'b0111;   // R4, R9
         3'b0_10: return 4'b0011;   // R4
         3'b0_11: return 4'b0001;   // R4
         3'b1_00: return 4'b0000;   // R7
         3'b1_01: return 4'b1000;   // R6
         3'b1_10: return 4'b1100;   // R6
         default: return 4'b1110;   // R6, R9
      endcase
   endfunction

   function automatic logic [31:0] model_data(logic [31:0] d, logic [3:0] be);
      return d & {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};  // R5, R8
   endfunction

   task automatic send(input logic mode, input logic [31:0] addr,
                       input logic [31:0] data, input string tag);
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1;
      req_mode  = mode;
      req_addr  = addr;
      req_data  = data;
      e.be   = model_be(mode, addr[1:0]);
      e.wv   = (e.be != 4'b0000);
      e.pv   = (e.be == 4'b0000);
      e.addr = {addr[31:2], 2'b00};   // R3
      e.data = model_data(data, e.be);
      e.due  = cyc + 1;
      e.tag  = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         req_valid = 1'b0;
         req_addr  = '0;
         req_data  = '0;
      end
   endtask

   task automatic step_lfsr();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // monitor: pops the scoreboard as responses appear
   always @(negedge clk) begin
      if (mon_on) begin
         if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (wr_valid !== e.wv || probe_valid !== e.pv || wr_addr !== e.addr ||
                wr_data !== e.data || wr_be !== e.be) begin
               fails++;
               $display("FAIL %s: got wv=%b pv=%b addr=%h data=%h be=%b, expected wv=%b pv=%b addr=%h data=%h be=%b",
                        e.tag, wr_valid, probe_valid, wr_addr, wr_data, wr_be,
                        e.wv, e.pv, e.addr, e.data, e.be);
            end
         end else begin
            checks++;
            if (wr_valid !== 1'b0 || probe_valid !== 1'b0) begin
               fails++;
               $display("FAIL R2 idle: got wv=%b pv=%b, expected wv=0 pv=0",
                        wr_valid, probe_valid);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state during reset
      checks++;
      if (wr_valid !== 1'b0 || probe_valid !== 1'b0 || wr_be !== 4'b0 ||
          wr_data !== 32'b0 || wr_addr !== 32'b0) begin
         fails++;
         $display("FAIL R1 in reset: got wv=%b pv=%b be=%b data=%h addr=%h, expected all zero",
                  wr_valid, probe_valid, wr_be, wr_data, wr_addr);
      end
      rst_n = 1'b1;
      @(negedge clk);
      // R1: state after release, before any request
      checks++;
      if (wr_valid !== 1'b0 || probe_valid !== 1'b0 || wr_be !== 4'b0 ||
          wr_data !== 32'b0 || wr_addr !== 32'b0) begin
         fails++;
         $display("FAIL R1 after release: got wv=%b pv=%b be=%b data=%h addr=%h, expected all zero",
                  wr_valid, probe_valid, wr_be, wr_data, wr_addr);
      end
      mon_on = 1'b1;

      // leading-edge mode, every offset, separated by idle cycles
      send(1'b0, 32'h1000_0040, 32'hA1B2_C3D4, "R4 R5 lead off0"); idle(1);
      send(1'b0, 32'h1000_0041, 32'hA1B2_C3D4, "R9 R5 lead off1"); idle(1);
      send(1'b0, 32'h1000_0042, 32'hA1B2_C3D4, "R4 R5 lead off2"); idle(1);
      send(1'b0, 32'h1000_0043, 32'hA1B2_C3D4, "R4 R8 lead off3"); idle(2);

      // trailing-edge mode, every offset
      send(1'b1, 32'h2000_0103, 32'h5566_7788, "R9 R6 trail off3"); idle(1);
      send(1'b1, 32'h2000_0102, 32'h5566_7788, "R6 trail off2"); idle(1);
      send(1'b1, 32'h2000_0101, 32'h5566_7788, "R6 R8 trail off1"); idle(1);
      send(1'b1, 32'h2000_0100, 32'h5566_7788, "R7 trail off0 probe"); idle(3);

      // back-to-back burst
      for (int i = 0; i < 40; i++) begin
         step_lfsr();
         send(lfsr[7], lfsr ^ 32'h0F0F_0000, {lfsr[15:0], lfsr[31:16]},
              "R10 R3 burst");
      end
      idle(2);

      // gapped traffic with mixed modes
      for (int i = 0; i < 30; i++) begin
         step_lfsr();
         send(lfsr[3], {lfsr[27:0], lfsr[31:28]}, ~lfsr, "R2 R3 gapped");
         idle(1 + (i % 3));
      end
      idle(4);

      // R2: every expected response has been seen
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R2 leftover: got %0d pending responses, expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule